// File: doc/BRIEF.md
# Soft-Ramp Multichannel Volume Control

This block attenuates a group of signed audio channels (six by default, 24 bits each) under control of per-channel attenuation codes, one code step per decibel from 0 dB down to -127 dB. One shared strobe marks each sample period, and every channel's output register updates on it. A single-volume switch lets the channel-0 code drive all channels. How a new code reaches the applied level depends on a 2-bit step policy: immediately, at the next sign change of the channel's samples, one decibel per sample period, or one decibel per sign change. Both zero-cross policies have a timeout, so a stalled signal cannot hold off a change for ever.

The block also handles system events. A filter-change request ramps every channel down to silence and reports when the change is safe, then restores the programmed levels when the request drops. A clock-error input silences all channels at once. An optional recovery ramp then brings the levels back one step per sample. The block drives per-channel mute flags, which can be routed out one per channel, as one combined flag, or as one flag per channel pair.

Top module: `vol_ramp`

## Requirements
- R1: On each cycle with `smp_stb` high, channel c's output becomes `(x * M[L%6]) >>> (16 + L/6)` truncated to 24 bits. Here x is the channel's input sample, L is the channel's applied level before that edge (0..127), and M = {65536, 58409, 52057, 46396, 41350, 36854}. The output holds its value on cycles without a strobe.
- R2: While `rst_n` is low, and for the first 4 strobes after reset, all outputs are 0 and every channel's mute flag is 1. After reset the applied level of every channel is 0 (no attenuation).
- R3: With `single_vol` low, channel c takes its code from `vol_code[8c+7:8c]`. With it high, all channels take the code from `vol_code[7:0]`.
- R4: With `step_pol` = 00, a strobe sets the applied level to the target.
- R5: With `step_pol` = 01, a differing target is applied whole on the first strobe whose sample sign bit differs from the previous sample's sign bit. If no such strobe comes, it is applied on the 512th strobe with the change pending. That strobe's output still uses the old level.
- R6: With `step_pol` = 10, each strobe moves the applied level one step toward the target.
- R7: With `step_pol` = 11, the applied level moves one step toward the target only on a sign-change strobe, or on a timeout strobe as in R5.
- R8: A code of 128 or more, or `mute_req` high, sets the target to the mute level 128. At that level the output is 0 and the channel's mute flag is 1.
- R9: With `fm_ramp_en` high and `fm_req` high, the target of every channel is 128. `fm_safe` is high only once all channels are at 128. With `fm_ramp_en` low, `fm_safe` follows `fm_req` and levels are not affected. When `fm_req` drops, the levels return to the programmed targets under the step policy.
- R10: While `clk_err` is high, every mute flag is 1 at once, and the applied levels are forced to 128 from the next edge. Strobes then produce 0.
- R11: After `clk_err` falls, with `err_ramp_en` high each channel ramps one step per strobe from 128 toward its target, whatever the step policy. With `err_ramp_en` low the normal step policy applies.
- R12: For `mute_map` = 01, `mute_o[0]` is the AND of all channel flags and the other bits are 0. For 11, `mute_o[k]` is the AND of the flags of channels 2k and 2k+1, and the upper half is 0. For 00 or 10, `mute_o[c]` is channel c's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | One-cycle pulse per sample period |
| smp_in | input | NCH*DW | Input samples, channel c at bits [DW*c +: DW] |
| vol_code | input | NCH*CW | Attenuation codes in dB, channel c at [CW*c +: CW] |
| single_vol | input | 1 | Channel-0 code drives all channels |
| step_pol | input | 2 | 00 immediate, 01 zero-cross, 10 ramp, 11 ramp on zero-cross |
| mute_req | input | 1 | Request silence on all channels |
| clk_err | input | 1 | Clock ratio error, silences at once |
| err_ramp_en | input | 1 | Ramp up after an error clears |
| fm_req | input | 1 | Filter change requested |
| fm_ramp_en | input | 1 | Ramp to silence around filter changes |
| mute_map | input | 2 | Mute flag routing select |
| smp_out | output | NCH*DW | Attenuated samples |
| mute_o | output | NCH | Routed mute flags |
| fm_safe | output | 1 | Filter change may proceed |

## Verification
The scaling path gets codes that hit every mantissa entry, whole-6 dB shifts, full-scale positive and negative samples at the deepest level, and a small negative value that shows floor rather than truncate-to-zero rounding. Sample streams of constant sign are set against alternating-sign streams. This separates the zero-cross policies from the immediate and ramp policies, and a 512-strobe constant stream isolates the timeout. The ramp policies are judged on the output of each successive strobe, which shows the level moved exactly one step. Error recovery is run with and without the ramp enable. The second strobe after the clear then shows a near-silent output in one case and full scale in the other.

// File: rtl/vol_ramp.sv
module vol_ramp #(
  parameter int NCH      = 6,
  parameter int DW       = 24,
  parameter int CW       = 8,
  parameter int ZC_LIMIT = 512,
  parameter int INIT_SMP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [NCH*DW-1:0] smp_in,
  input  logic [NCH*CW-1:0] vol_code,
  input  logic              single_vol,
  input  logic [1:0]        step_pol,
  input  logic              mute_req,
  input  logic              clk_err,
  input  logic              err_ramp_en,
  input  logic              fm_req,
  input  logic              fm_ramp_en,
  input  logic [1:0]        mute_map,
  output logic [NCH*DW-1:0] smp_out,
  output logic [NCH-1:0]    mute_o,
  output logic              fm_safe
);
  localparam int PW = DW + 18;
  localparam int ZW = $clog2(ZC_LIMIT);
  localparam int IW = $clog2(INIT_SMP + 1);
  localparam int NP = NCH / 2;
  localparam logic [CW-1:0] MUTE = CW'(1) << (CW - 1);

  logic [IW-1:0]     init_cnt;
  logic              init_busy;
  logic [NCH-1:0]    chan_mute;
  logic [NCH-1:0]    at_mute;
  logic [NCH*CW-1:0] lvl_flat;
  logic [NCH*CW-1:0] tgt_flat;
  logic [NCH-1:0]    rec_flat;
  logic [NP-1:0]     pair_mute;
  logic              kill;

  assign init_busy = init_cnt != IW'(INIT_SMP);
  assign kill      = mute_req | (fm_req & fm_ramp_en);

  always_ff @(posedge clk) begin
    if (!rst_n)                     init_cnt <= '0;
    else if (smp_stb && init_busy)  init_cnt <= init_cnt + 1'b1;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0]        code, tgt, lvl_r, lvl_d, step, q, r;
    logic [ZW-1:0]        cnt_r, cnt_d;
    logic                 prev_r, rec_r, rec_d, sgn, pending, gate;
    logic signed [DW-1:0] x, out_r, scaled;
    logic [16:0]          mant;
    logic signed [PW-1:0] prod;

    assign code    = single_vol ? vol_code[CW-1:0] : vol_code[c*CW +: CW];
    assign tgt     = (kill || code >= MUTE) ? MUTE : code;
    assign x       = smp_in[c*DW +: DW];
    assign sgn     = x[DW-1];
    assign pending = lvl_r != tgt;
    assign step    = (lvl_r < tgt) ? lvl_r + 1'b1 : lvl_r - 1'b1;
    assign gate    = (sgn != prev_r) || (cnt_r == ZW'(ZC_LIMIT - 1));
    assign q       = lvl_r / CW'(6);
    assign r       = lvl_r % CW'(6);

    always_comb begin
      case (r)
        CW'(0):  mant = 17'd65536;
        CW'(1):  mant = 17'd58409;
        CW'(2):  mant = 17'd52057;
        CW'(3):  mant = 17'd46396;
        CW'(4):  mant = 17'd41350;
        default: mant = 17'd36854;
      endcase
    end

    assign prod   = PW'(x) * PW'($signed({1'b0, mant}));
    assign scaled = DW'(prod >>> (32'd16 + 32'(q)));

    always_comb begin
      lvl_d = lvl_r;
      cnt_d = cnt_r;
      rec_d = rec_r;
      if (clk_err) begin
        lvl_d = MUTE;
        cnt_d = '0;
        rec_d = err_ramp_en;
      end else if (smp_stb) begin
        if (rec_r) begin
          cnt_d = '0;
          if (pending) lvl_d = step;
          else         rec_d = 1'b0;
        end else begin
          case (step_pol)
            2'b00: begin
              lvl_d = tgt;
              cnt_d = '0;
            end
            2'b10: begin
              if (pending) lvl_d = step;
              cnt_d = '0;
            end
            default: begin
              if (!pending) cnt_d = '0;
              else if (gate) begin
                lvl_d = step_pol[1] ? step : tgt;
                cnt_d = '0;
              end else cnt_d = cnt_r + 1'b1;
            end
          endcase
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl_r  <= '0;
        cnt_r  <= '0;
        rec_r  <= 1'b0;
        prev_r <= 1'b0;
        out_r  <= '0;
      end else begin
        lvl_r <= lvl_d;
        cnt_r <= cnt_d;
        rec_r <= rec_d;
        if (smp_stb) begin
          prev_r <= sgn;
          out_r  <= (init_busy || clk_err || lvl_r >= MUTE) ? '0 : scaled;
        end
      end
    end

    assign smp_out[c*DW +: DW] = out_r;
    assign at_mute[c]          = lvl_r == MUTE;
    assign chan_mute[c]        = init_busy | clk_err | at_mute[c];
    assign lvl_flat[c*CW +: CW] = lvl_r;
    assign tgt_flat[c*CW +: CW] = tgt;
    assign rec_flat[c]          = rec_r;
  end

  for (genvar k = 0; k < NP; k++) begin : g_pair
    assign pair_mute[k] = chan_mute[2*k] & chan_mute[2*k+1];
  end

  always_comb begin
    case (mute_map)
      2'b01:   mute_o = {{(NCH-1){1'b0}}, &chan_mute};
      2'b11:   mute_o = {{(NCH-NP){1'b0}}, pair_mute};
      default: mute_o = chan_mute;
    endcase
  end

  assign fm_safe = fm_req & (~fm_ramp_en | (&at_mute));
endmodule

module vol_ramp_chk #(
  parameter int NCH = 6,
  parameter int DW  = 24,
  parameter int CW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_stb,
  input logic              clk_err,
  input logic              fm_safe,
  input logic              fm_ramp_en,
  input logic [1:0]        step_pol,
  input logic [1:0]        mute_map,
  input logic [NCH-1:0]    mute_o,
  input logic [NCH*DW-1:0] smp_out,
  input logic [CW-1:0]     lvl0,
  input logic [CW-1:0]     tgt0,
  input logic              rec0
);
  localparam logic [CW-1:0] MUTE = CW'(1) << (CW - 1);

  // R1
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(smp_out));

  // R4
  imm_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pol == 2'b00 && smp_stb && !clk_err && !rec0) |=> lvl0 == $past(tgt0));

  // R6
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pol == 2'b10 && !clk_err) |=>
      (lvl0 == $past(lvl0) || lvl0 == $past(lvl0) + 1'b1 || lvl0 == $past(lvl0) - 1'b1));

  // R9
  fm_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fm_safe && fm_ramp_en && mute_map == 2'b00) |-> &mute_o);

  // R10
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_err && mute_map == 2'b00) |-> &mute_o);

  // R10
  err_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_err |=> lvl0 == MUTE);
endmodule

bind vol_ramp vol_ramp_chk #(.NCH(NCH), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .clk_err(clk_err),
  .fm_safe(fm_safe), .fm_ramp_en(fm_ramp_en), .step_pol(step_pol),
  .mute_map(mute_map), .mute_o(mute_o), .smp_out(smp_out),
  .lvl0(lvl_flat[CW-1:0]), .tgt0(tgt_flat[CW-1:0]), .rec0(rec_flat[0])
);

// File: tb/test_vol_ramp.sv
module test_vol_ramp;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;
  localparam int DW  = 24;
  localparam int CW  = 8;
  localparam int NV  = 11;

  localparam int TV_CODE [NV] = '{0, 6, 12, 1, 5, 7, 3, 6, 127, 127, 200};
  localparam int TV_X    [NV] = '{1234, 1000, 1000, 65536, 65536, 65536,
                                  -65536, -3, 8388607, -8388608, 50000};
  localparam int TV_EXP  [NV] = '{1234, 500, 250, 58409, 36854, 29204,
                                  -46396, -2, 3, -4, 0};

  logic              clk = 0;
  logic              rst_n = 0;
  logic              smp_stb = 0;
  logic [NCH*DW-1:0] smp_in = '0;
  logic [NCH*CW-1:0] vol_code = '0;
  logic              single_vol = 0;
  logic [1:0]        step_pol = 2'b00;
  logic              mute_req = 0;
  logic              clk_err = 0;
  logic              err_ramp_en = 0;
  logic              fm_req = 0;
  logic              fm_ramp_en = 0;
  logic [1:0]        mute_map = 2'b00;
  logic [NCH*DW-1:0] smp_out;
  logic [NCH-1:0]    mute_o;
  logic              fm_safe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vol_ramp i_vol_ramp (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_in(smp_in),
    .vol_code(vol_code), .single_vol(single_vol), .step_pol(step_pol),
    .mute_req(mute_req), .clk_err(clk_err), .err_ramp_en(err_ramp_en),
    .fm_req(fm_req), .fm_ramp_en(fm_ramp_en), .mute_map(mute_map),
    .smp_out(smp_out), .mute_o(mute_o), .fm_safe(fm_safe)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outc(input int c);
    return int'($signed(smp_out[c*DW +: DW]));
  endfunction

  task automatic set_all(input int code);
    for (int c = 0; c < NCH; c++) vol_code[c*CW +: CW] = CW'(code);
  endtask

  task automatic strobe(input int x);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) smp_in[c*DW +: DW] = DW'(x);
    smp_stb = 1;
    @(negedge clk);
    smp_stb = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 flags in reset", int'(mute_o), 'h3f);
    check("R2 out in reset", outc(0), 0);
    rst_n = 1;
    for (int i = 0; i < 4; i++) begin
      strobe(65536);
      check("R2 init silent", outc(2), 0);
    end
    check("R2 flags after init", int'(mute_o), 0);

    for (int i = 0; i < NV; i++) begin
      set_all(TV_CODE[i]);
      strobe(0);
      strobe(TV_X[i]);
      check("R1 R4 R8 table ch0", outc(0), TV_EXP[i]);
      check("R1 R4 R8 table ch5", outc(5), TV_EXP[i]);
    end

    for (int c = 0; c < NCH; c++) vol_code[c*CW +: CW] = CW'(6*c);
    strobe(0);
    strobe(1024);
    for (int c = 0; c < NCH; c++) check("R3 per-channel", outc(c), 1024 >>> c);
    single_vol = 1;
    vol_code[CW-1:0] = 8'd12;
    strobe(0);
    strobe(1024);
    for (int c = 0; c < NCH; c++) check("R3 single volume", outc(c), 256);
    single_vol = 0;
    set_all(0);
    strobe(0);

    mute_req = 1;
    strobe(0);
    check("R8 mute flags", int'(mute_o), 'h3f);
    strobe(1000);
    check("R8 mute out", outc(1), 0);
    mute_req = 0;
    strobe(0);
    strobe(1000);
    check("R8 unmute out", outc(1), 1000);

    step_pol = 2'b10;
    set_all(3);
    strobe(65536); check("R6 ramp 0", outc(0), 65536);
    strobe(65536); check("R6 ramp 1", outc(0), 58409);
    strobe(65536); check("R6 ramp 2", outc(0), 52057);
    strobe(65536); check("R6 ramp 3", outc(0), 46396);
    strobe(65536); check("R6 ramp hold", outc(0), 46396);

    step_pol = 2'b01;
    set_all(0);
    strobe(65536); check("R5 no crossing a", outc(0), 46396);
    strobe(65536); check("R5 no crossing b", outc(0), 46396);
    strobe(-65536); check("R5 crossing strobe", outc(0), -46396);
    strobe(65536); check("R5 after crossing", outc(0), 65536);

    set_all(6);
    for (int i = 0; i < 512; i++) strobe(100);
    check("R5 timeout strobe", outc(0), 100);
    strobe(100);
    check("R5 after timeout", outc(0), 50);

    step_pol = 2'b11;
    set_all(4);
    strobe(65536);  check("R7 no crossing", outc(0), 32768);
    strobe(-65536); check("R7 cross 1", outc(0), -32768);
    strobe(65536);  check("R7 cross 2", outc(0), 36854);
    strobe(-65536); check("R7 cross 3", outc(0), -41350);
    strobe(65536);  check("R7 settled", outc(0), 41350);

    step_pol = 2'b10;
    fm_ramp_en = 1;
    @(negedge clk);
    fm_req = 1;
    #1 check("R9 not yet safe", int'(fm_safe), 0);
    for (int i = 0; i < 123; i++) strobe(65536);
    check("R9 safe before last step", int'(fm_safe), 0);
    strobe(65536);
    check("R9 safe", int'(fm_safe), 1);
    check("R9 flags", int'(mute_o), 'h3f);
    strobe(65536);
    check("R9 silent", outc(3), 0);
    fm_req = 0;
    for (int i = 0; i < 124; i++) strobe(65536);
    strobe(65536);
    check("R9 restored", outc(3), 41350);
    fm_ramp_en = 0;
    @(negedge clk);
    fm_req = 1;
    #1 check("R9 direct safe", int'(fm_safe), 1);
    strobe(65536);
    check("R9 level untouched", outc(3), 41350);
    fm_req = 0;

    step_pol = 2'b00;
    set_all(0);
    strobe(0);
    err_ramp_en = 1;
    @(negedge clk);
    clk_err = 1;
    #1 check("R10 flags", int'(mute_o), 'h3f);
    strobe(8388607);
    check("R10 silent", outc(0), 0);
    clk_err = 0;
    strobe(8388607); check("R11 ramp first", outc(0), 0);
    strobe(8388607); check("R11 ramp second", outc(0), 3);
    for (int i = 0; i < 126; i++) strobe(0);
    strobe(8388607);
    check("R11 ramp done", outc(0), 8388607);
    err_ramp_en = 0;
    @(negedge clk);
    clk_err = 1;
    repeat (2) @(negedge clk);
    clk_err = 0;
    strobe(8388607); check("R11 jump first", outc(0), 0);
    strobe(8388607); check("R11 jump second", outc(0), 8388607);

    mute_map = 2'b01;
    set_all(200);
    strobe(0);
    check("R12 combined all", int'(mute_o), 1);
    vol_code[5*CW +: CW] = 8'd0;
    strobe(0);
    check("R12 combined partial", int'(mute_o), 0);
    mute_map = 2'b11;
    set_all(0);
    vol_code[0 +: CW] = 8'd200;
    vol_code[CW +: CW] = 8'd200;
    strobe(0);
    check("R12 pairs one", int'(mute_o), 'b000001);
    vol_code[2*CW +: CW] = 8'd200;
    vol_code[3*CW +: CW] = 8'd200;
    strobe(0);
    check("R12 pairs two", int'(mute_o), 'b000011);
    mute_map = 2'b00;
    #1 check("R12 per channel", int'(mute_o), 'b001111);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule